// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides which hardware thread is allowed to fetch in the current cycle of a simultaneous-multithreading front end. Each cycle it looks at the fetch state code of every thread, at an active-thread mask, and at a per-thread back-end queue occupancy count. It then returns up to `NUM_PICKS` thread IDs, each with a valid bit, so that several threads can fetch in one cycle. The grant outputs are combinational from the inputs and from an internal thread-order list. Only that list is stored.

A policy input selects how the selector chooses. In single-thread operation only thread 0 is considered. In round-robin operation the selector walks a stored order list and sends each granted thread to the back of that list. In occupancy operation it favours the thread with the emptiest back-end queue. When no thread qualifies, no further picks are made in that cycle. While a drain request is held, no thread is granted.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread qualifies only when its `active_i` bit is 1 and its 3-bit state code is 0 (running), 1 (idle) or 2 (line delivered). Codes 3 (squashing), 4 (blocked), 5 (awaiting response), 6 (awaiting retry) and 7 (trap or quiesce hold) are never granted.
- R2: With policy code 1 (round robin), each pick scans the order list from its first to its last entry and grants the first qualifying thread not yet granted in this cycle. That thread then moves to the last list position before the next pick, and the updated list is kept for the next cycle.
- R3: After reset the order list holds the thread IDs in ascending order, so the first round-robin picks return threads 0 and then 1.
- R4: With policy code 0 (single thread), only thread 0 can be granted, and only when it qualifies. This code is legal only when `NUM_THREADS` is 1.
- R5: With one thread configured, under policy codes 0, 1 and 2, pick 0 returns thread 0 when it qualifies and returns no grant otherwise.
- R6: A pick that finds no qualifying thread forces no grant for every later pick in the same cycle.
- R7: While `drain_i` is 1, no pick is granted and the order list keeps its contents.
- R8: With policy code 2 (occupancy), each pick grants the qualifying, not-yet-granted thread with the smallest occupancy count. Ties go to the lowest thread ID. The order list is left unchanged.
- R9: No thread is granted twice in the same cycle.
- R10: Policy code 3 is reserved and grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | 0 single thread, 1 round robin, 2 occupancy, 3 reserved |
| drain_i | input | 1 | Drain pending; suppresses all grants |
| active_i | input | NUM_THREADS | Per-thread active mask |
| state_i | input | 3*NUM_THREADS | Per-thread fetch state code, thread t at bits [3t+2:3t] |
| occ_i | input | CNT_W*NUM_THREADS | Per-thread back-end queue count, thread t at bits [CNT_W*t +: CNT_W] |
| grant_valid_o | output | NUM_PICKS | Pick k produced a grant |
| grant_tid_o | output | NUM_PICKS*TID_W | Thread ID of pick k at bits [TID_W*k +: TID_W] |

## Verification
Round robin is first run with every thread running, straight out of reset. This separates a rotating list from a fixed priority, because the second cycle must return threads 2 and 3. Mixed state patterns place each ineligible code next to each eligible code, which shows whether the state filter is exact. A single eligible thread then shows that the second pick stops. Round robin runs again after drain and occupancy cycles, so a list that moved during those cycles would appear as a wrong grant order. Occupancy patterns with tied counts, and with the cheapest thread blocked, tell the minimum search apart from the lowest-ID tie break. A one-thread instance is run under every policy code.

// File: rtl/fts_pkg.sv
package fts_pkg;

   typedef enum logic [2:0] {
      ST_RUN        = 3'd0,
      ST_IDLE       = 3'd1,
      ST_FILLED     = 3'd2,
      ST_SQUASH     = 3'd3,
      ST_BLOCKED    = 3'd4,
      ST_WAIT_RSP   = 3'd5,
      ST_WAIT_RETRY = 3'd6,
      ST_HOLD       = 3'd7
   } fstate_e;

   typedef enum logic [1:0] {
      POL_SINGLE = 2'd0,
      POL_RR     = 2'd1,
      POL_OCC    = 2'd2,
      POL_OFF    = 2'd3
   } fpol_e;

   // Running, idle and line-delivered states may fetch.
   function automatic logic may_fetch(input logic [2:0] code);
      return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_FILLED);
   endfunction

endpackage

// File: rtl/fts_eligible.sv
module fts_eligible
   import fts_pkg::*;
#(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS-1:0]      active_i,
   input  logic [NUM_THREADS-1:0][2:0] state_i,
   output logic [NUM_THREADS-1:0]      elig_o
);

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign elig_o[t] = active_i[t] & may_fetch(state_i[t]);
   end

endmodule

// File: rtl/fts_pick.sv
module fts_pick
   import fts_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2,
   parameter int CNT_W       = 6
) (
   input  logic [1:0]                              policy_i,
   input  logic                                    enable_i,
   input  logic [NUM_THREADS-1:0]                  cand_i,
   input  logic [NUM_THREADS-1:0][CNT_W-1:0]       occ_i,
   input  logic [NUM_THREADS-1:0][TID_W-1:0]       order_i,
   output logic                                    valid_o,
   output logic [TID_W-1:0]                        tid_o,
   output logic [NUM_THREADS-1:0][TID_W-1:0]       order_o
);

   logic             found;
   logic [TID_W-1:0] win;
   logic [CNT_W-1:0] best;
   int               pos;

   always_comb begin
      found = 1'b0;
      win   = '0;
      best  = '0;
      pos   = 0;
      case (policy_i)
         POL_SINGLE: begin
            found = cand_i[0];
         end
         POL_RR: begin
            for (int i = 0; i < NUM_THREADS; i++) begin
               if (!found && cand_i[order_i[i]]) begin
                  found = 1'b1;
                  win   = order_i[i];
                  pos   = i;
               end
            end
         end
         POL_OCC: begin
            for (int t = 0; t < NUM_THREADS; t++) begin
               if (cand_i[t] && (!found || occ_i[t] < best)) begin
                  found = 1'b1;
                  win   = TID_W'(t);
                  best  = occ_i[t];
               end
            end
         end
         default: found = 1'b0;
      endcase
      valid_o = enable_i & found;
      tid_o   = win;
   end

   // Granted thread leaves its slot and is appended at the tail.
   always_comb begin
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (!(valid_o && policy_i == POL_RR) || i < pos)
            order_o[i] = order_i[i];
         else if (i < NUM_THREADS - 1)
            order_o[i] = order_i[(i + 1) % NUM_THREADS];
         else
            order_o[i] = win;
      end
   end

endmodule

// File: rtl/fts_order_reg.sv
module fts_order_reg #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load_i,
   input  logic [NUM_THREADS-1:0][TID_W-1:0]   order_d,
   output logic [NUM_THREADS-1:0][TID_W-1:0]   order_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
      end else if (load_i) begin
         order_q <= order_d;
      end
   end

   // Every thread must appear exactly once in the stored list.
   logic [NUM_THREADS-1:0] present;
   always_comb begin
      present = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (int'(order_q[i]) < NUM_THREADS) present[order_q[i]] = 1'b1;
      end
   end

   p_order_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(present) == NUM_THREADS)
      else $error("order list lost a thread");

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
   import fts_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int NUM_PICKS   = 2,
   parameter int CNT_W       = 6,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   policy_i,
   input  logic                         drain_i,
   input  logic [NUM_THREADS-1:0]       active_i,
   input  logic [3*NUM_THREADS-1:0]     state_i,
   input  logic [CNT_W*NUM_THREADS-1:0] occ_i,
   output logic [NUM_PICKS-1:0]         grant_valid_o,
   output logic [NUM_PICKS*TID_W-1:0]   grant_tid_o
);

   if (NUM_THREADS < 1 || NUM_THREADS > 64) begin : g_bad_nt
      $error("NUM_THREADS must be 1..64");
   end
   if (NUM_PICKS < 1) begin : g_bad_np
      $error("NUM_PICKS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cw
      $error("CNT_W must be at least 1");
   end

   logic [NUM_THREADS-1:0][2:0]            st_a;
   logic [NUM_THREADS-1:0][CNT_W-1:0]      occ_a;
   logic [NUM_THREADS-1:0]                 elig;
   logic [NUM_PICKS-1:0][NUM_THREADS-1:0]  cand;
   logic [NUM_PICKS-1:0]                   go;
   logic [NUM_PICKS-1:0]                   vld;
   logic [NUM_PICKS-1:0][TID_W-1:0]        tid;
   logic [NUM_PICKS:0][NUM_THREADS-1:0][TID_W-1:0] ord;
   logic [NUM_THREADS-1:0][TID_W-1:0]      order_q;

   assign st_a  = state_i;
   assign occ_a = occ_i;

   fts_eligible #(.NUM_THREADS(NUM_THREADS)) elig_i (
      .active_i (active_i),
      .state_i  (st_a),
      .elig_o   (elig)
   );

   assign cand[0] = elig;
   assign go[0]   = ~drain_i;
   assign ord[0]  = order_q;

   for (genvar k = 0; k < NUM_PICKS; k++) begin : g_pick
      fts_pick #(
         .NUM_THREADS (NUM_THREADS),
         .TID_W       (TID_W),
         .CNT_W       (CNT_W)
      ) pick_i (
         .policy_i (policy_i),
         .enable_i (go[k]),
         .cand_i   (cand[k]),
         .occ_i    (occ_a),
         .order_i  (ord[k]),
         .valid_o  (vld[k]),
         .tid_o    (tid[k]),
         .order_o  (ord[k+1])
      );
      if (k + 1 < NUM_PICKS) begin : g_next
         assign go[k+1]   = vld[k];
         assign cand[k+1] = cand[k] &
            ~(vld[k] ? (NUM_THREADS'(1) << tid[k]) : NUM_THREADS'(0));
      end
   end

   fts_order_reg #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) order_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (~drain_i),
      .order_d (ord[NUM_PICKS]),
      .order_q (order_q)
   );

   assign grant_valid_o = vld;
   assign grant_tid_o   = tid;

   // ---------------- assertions ----------------
   logic [TID_W-1:0] last_tid;
   logic             occ_bad;
   always_comb begin
      last_tid = '0;
      for (int k = 0; k < NUM_PICKS; k++) if (vld[k]) last_tid = tid[k];
      occ_bad = 1'b0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (active_i[t] && state_i[3*t +: 3] <= 3'd2 &&
             occ_i[CNT_W*t +: CNT_W] < occ_i[CNT_W*tid[0] +: CNT_W])
            occ_bad = 1'b1;
      end
   end

   p_drain_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drain_i |-> (vld == '0));

   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_OFF) |-> (vld == '0));

   p_rr_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_RR && !drain_i && vld[0]) |=>
      (order_q[NUM_THREADS-1] == $past(last_tid)));

   p_occ_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_OCC && vld[0]) |-> !occ_bad);

   if (NUM_THREADS > 1) begin : g_multi
      p_single_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
         policy_i != POL_SINGLE);
   end

   for (genvar k = 0; k < NUM_PICKS; k++) begin : g_chk
      p_grant_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
         vld[k] |-> (active_i[tid[k]] && state_i[3*tid[k] +: 3] <= 3'd2));
      if (k > 0) begin : g_later
         p_stop_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !vld[k-1] |-> !vld[k]);
         for (genvar j = 0; j < k; j++) begin : g_pair
            p_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
               (vld[k] && vld[j]) |-> (tid[k] != tid[j]));
         end
      end
   end

endmodule

// File: tb/fetch_thread_sel_tb_top.sv
module fetch_thread_sel_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NT = 4;
   localparam int NP = 2;
   localparam int CW = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n = 1'b0;

   logic [1:0]     pol  = 2'd1;
   logic           drn  = 1'b0;
   logic [NT-1:0]  act  = '0;
   logic [3*NT-1:0] st  = '0;
   logic [CW*NT-1:0] occ = '0;
   logic [NP-1:0]  gv;
   logic [2*NP-1:0] gt;

   logic [1:0]     pol1 = 2'd1;
   logic           drn1 = 1'b0;
   logic [0:0]     act1 = '0;
   logic [2:0]     st1  = '0;
   logic [CW-1:0]  occ1 = '0;
   logic [NP-1:0]  gv1;
   logic [NP-1:0]  gt1;

   fetch_thread_sel #(.NUM_THREADS(NT), .NUM_PICKS(NP), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .policy_i(pol), .drain_i(drn),
      .active_i(act), .state_i(st), .occ_i(occ),
      .grant_valid_o(gv), .grant_tid_o(gt)
   );

   fetch_thread_sel #(.NUM_THREADS(1), .NUM_PICKS(NP), .CNT_W(CW)) dut_one_i (
      .clk(clk), .rst_n(rst_n), .policy_i(pol1), .drain_i(drn1),
      .active_i(act1), .state_i(st1), .occ_i(occ1),
      .grant_valid_o(gv1), .grant_tid_o(gt1)
   );

   typedef struct {
      bit    v0, v1, ov;
      int    t0, t1;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   rr[NT];
   int   nchk = 0;
   int   nfail = 0;
   bit   done = 0;

   function automatic bit qual(bit a, logic [2:0] s);
      return a && (s <= 3'd2);
   endfunction

   function automatic logic [3*NT-1:0] mk_st(int s0, int s1, int s2, int s3);
      return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
   endfunction

   function automatic logic [CW*NT-1:0] mk_occ(int c0, int c1, int c2, int c3);
      return {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
   endfunction

   task automatic chk(bit ok, string tag, string what, int got, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected grants.
   task automatic step(input logic [1:0] p, input logic d, input logic [NT-1:0] a,
                       input logic [3*NT-1:0] s, input logic [CW*NT-1:0] o,
                       input logic [1:0] p1, input logic d1, input logic a1,
                       input logic [2:0] s1, input string tag);
      exp_t e;
      bit   taken[NT];
      bit   stop;
      @(negedge clk);
      pol = p; drn = d; act = a; st = s; occ = o;
      pol1 = p1; drn1 = d1; act1 = a1; st1 = s1; occ1 = CW'(3);
      e.v0 = 0; e.v1 = 0; e.t0 = 0; e.t1 = 0; e.tag = tag;
      for (int t = 0; t < NT; t++) taken[t] = 0;
      stop = d || (p == 2'd3);
      for (int k = 0; k < NP; k++) begin
         int g;
         int bo;
         g = -1;
         bo = 0;
         if (!stop) begin
            if (p == 2'd1) begin
               for (int i = 0; i < NT; i++)
                  if (g < 0 && !taken[rr[i]] && qual(a[rr[i]], s[rr[i]*3 +: 3])) g = rr[i];
            end else if (p == 2'd2) begin
               for (int t = 0; t < NT; t++)
                  if (!taken[t] && qual(a[t], s[t*3 +: 3]) &&
                      (g < 0 || int'(o[t*CW +: CW]) < bo)) begin
                     g = t; bo = int'(o[t*CW +: CW]);
                  end
            end else if (p == 2'd0) begin
               if (!taken[0] && qual(a[0], s[2:0])) g = 0;
            end
         end
         if (g < 0) stop = 1;
         else begin
            taken[g] = 1;
            if (k == 0) begin e.v0 = 1; e.t0 = g; end
            else begin e.v1 = 1; e.t1 = g; end
            if (p == 2'd1) begin
               int pos;
               pos = 0;
               for (int i = 0; i < NT; i++) if (rr[i] == g) pos = i;
               for (int i = pos; i < NT - 1; i++) rr[i] = rr[i+1];
               rr[NT-1] = g;
            end
         end
      end
      e.ov = !d1 && (p1 != 2'd3) && qual(a1, s1);
      sb.push_back(e);
   endtask

   // Monitor: compares outputs away from the clock edge.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(gv[0] == e.v0, e.tag, "pick0 valid", int'(gv[0]), int'(e.v0));
            if (e.v0) chk(int'(gt[1:0]) == e.t0, e.tag, "pick0 tid", int'(gt[1:0]), e.t0);
            chk(gv[1] == e.v1, e.tag, "pick1 valid", int'(gv[1]), int'(e.v1));
            if (e.v1) chk(int'(gt[3:2]) == e.t1, e.tag, "pick1 tid", int'(gt[3:2]), e.t1);
            chk(gv1[0] == e.ov, {e.tag, " R5"}, "one-thread pick0", int'(gv1[0]), int'(e.ov));
            if (e.ov) chk(gt1[0] == 1'b0, "R5", "one-thread tid", int'(gt1[0]), 0);
            chk(gv1[1] == 1'b0, "R6", "one-thread pick1", int'(gv1[1]), 0);
         end
      end
   end

   initial begin
      for (int i = 0; i < NT; i++) rr[i] = i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R3: reset order, all running
      step(2'd1, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd0, 0, 1, 3'd0, "R3");
      step(2'd1, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd1, 0, 1, 3'd7, "R2");
      // R1: one of each code class
      step(2'd1, 0, 4'hF, mk_st(3,4,1,2), '0, 2'd2, 0, 1, 3'd1, "R1");
      // R6: single eligible thread, second pick stops
      step(2'd1, 0, 4'hF, mk_st(5,0,6,7), '0, 2'd0, 0, 1, 3'd3, "R6 R4");
      step(2'd1, 0, 4'h0, mk_st(0,0,0,0), '0, 2'd1, 0, 0, 3'd0, "R1 inactive");
      // R7: drain blocks grants, list frozen
      step(2'd1, 1, 4'hF, mk_st(0,0,0,0), '0, 2'd0, 1, 1, 3'd0, "R7");
      step(2'd1, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd2, 0, 1, 3'd2, "R7 list");
      // R8: occupancy with ties and blocked minimum
      step(2'd2, 0, 4'hF, mk_st(0,0,0,0), mk_occ(5,2,9,2), 2'd3, 0, 1, 3'd0, "R8 R10");
      step(2'd2, 0, 4'hF, mk_st(0,4,0,0), mk_occ(5,2,9,2), 2'd1, 0, 1, 3'd1, "R8");
      step(2'd1, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd0, 0, 1, 3'd2, "R2 R8");
      step(2'd3, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd2, 0, 1, 3'd4, "R10");
      step(2'd1, 0, 4'hF, mk_st(7,0,0,0), '0, 2'd1, 0, 1, 3'd0, "R9 R1");
      step(2'd2, 0, 4'hF, mk_st(0,0,0,0), mk_occ(4,4,4,4), 2'd0, 0, 1, 3'd1, "R8 tie");
      step(2'd1, 0, 4'hF, mk_st(0,0,0,0), '0, 2'd2, 1, 1, 3'd0, "R2 R9");
      @(negedge clk);
      wait (sb.size() == 0);
      #3;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule